// File: doc/BRIEF.md
# Dual-Output Level Interrupt Router

This block gathers up to 32 level-sensitive, active-high interrupt requests from on-board peripherals. Each request passes through a two-flop synchroniser into a raw status word. Four independent enable masks pick which status bits reach each of four outputs. Two outputs are ordinary interrupt lines and two are machine-check lines, one of each per processor core.

Every output is a registered OR of the status bits its mask enables. Nothing is latched and nothing needs acknowledging. An output stays high while an enabled source holds its request, and it drops once the source releases it.

Software reaches the status word and the masks through a simple 32-bit register port. A write strobe commits data on the clock edge. Read data comes from a register that is loaded every cycle from the word at the presented address.

Top module: `irq_fanout_router`

## Requirements
- R1: The status word at byte offset 0x00 equals the input vector as it stood two clock edges earlier, because of the two-flop synchroniser. It has no other source.
- R2: Bits 31:17 and bit 6 of the status word always read as zero. Those inputs never assert any output, whatever the masks hold.
- R3: After reset, all four mask registers read zero, all four outputs are low, and the read data is zero.
- R4: The interrupt-line mask for core n (n = 0, 1) is read/write at byte offset 0x10 + 4·n. Bit k set to 1 lets status bit k reach `irq_out[n]`; bit k at 0 blocks it.
- R5: The machine-check mask for core n (n = 0, 1) is read/write at byte offset 0x18 + 4·n. It gates status bits onto `mchk_out[n]` by the same rule.
- R6: Each output is a register loaded with the OR of (status AND its mask). An output changes one edge after a mask write and three edges after an input change.
- R7: The masks are not exclusive. An input enabled in several masks asserts every one of those outputs in the same cycle.
- R8: An output falls without any register access, three edges after the last enabled source deasserts.
- R9: Writes to offset 0x00, to an unmapped offset or to an unaligned offset change no register. Reads of any unmapped or unaligned offset return zero.
- R10: `bus_rdata` is registered. It shows the word at the address presented before a clock edge, starting just after that edge, and it holds its old value until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Level interrupt requests, asynchronous to clk |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, committed on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 2 | Interrupt line per core |
| mchk_out | output | 2 | Machine-check line per core |

## Verification
A mask write and an input change can reach the output register in the same cycle. One path goes through the one-stage mask register and the other through the two-stage synchroniser. The bench provokes this by raising a source bit on the very edge that writes the mask enabling it. It then judges that the interrupt line is still low after the second edge and rises exactly after the third. A second collision, a read issued while a source toggles, is judged by the status readback matching the input as it stood two edges before the read edge.

// File: rtl/irq_fanout_pkg.sv
package irq_fanout_pkg;

  localparam int unsigned STATUS_OFS = 32'h00;
  localparam int unsigned IRQ_BASE   = 32'h10;
  localparam int unsigned MCHK_BASE  = 32'h18;

  // Byte offset of mask index i; indices below num_core are interrupt
  // masks, the rest are machine-check masks.
  function automatic int unsigned mask_ofs(input int unsigned i,
                                           input int unsigned num_core);
    if (i < num_core) return IRQ_BASE + 4 * i;
    else              return MCHK_BASE + 4 * (i - num_core);
  endfunction

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
  parameter int unsigned       W    = 32,
  parameter logic [W-1:0]      RSVD = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      if (RSVD[b]) begin : g_tied
        assign sync_out[b] = 1'b0;
      end else begin : g_sync
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
          if (rst) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
          end else begin
            meta_q <= async_in[b];
            stab_q <= meta_q;
          end
        end
        assign sync_out[b] = stab_q;
      end
    end
  endgenerate

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_fanout_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CORE = 2,
  localparam int unsigned NUM_MASKS = 2 * NUM_CORE
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic [DATA_W-1:0]             status,
  output logic [NUM_MASKS*DATA_W-1:0]   mask_flat,
  output logic [DATA_W-1:0]             bus_rdata
);

  logic [NUM_MASKS-1:0] hit;
  logic                 status_hit;

  assign status_hit = (bus_addr == ADDR_W'(STATUS_OFS));

  genvar m;
  generate
    for (m = 0; m < NUM_MASKS; m++) begin : g_mask
      logic [DATA_W-1:0] mask_q;
      assign hit[m] = (bus_addr == ADDR_W'(mask_ofs(m, NUM_CORE)));
      always_ff @(posedge clk) begin
        if (rst)                mask_q <= '0;
        else if (bus_wr && hit[m]) mask_q <= bus_wdata;
      end
      assign mask_flat[m*DATA_W +: DATA_W] = mask_q;
    end
  endgenerate

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (status_hit) rd_mux = status;
    for (int i = 0; i < NUM_MASKS; i++)
      if (hit[i]) rd_mux = mask_flat[i*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  input  logic [W-1:0] enable,
  output logic         line_q
);

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= |(status & enable);
  end

endmodule

// File: rtl/irq_fanout_router.sv
module irq_fanout_router #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CORE = 2,
  parameter logic [31:0] RSVD     = 32'hFFFE_0040,
  localparam int unsigned NUM_MASKS = 2 * NUM_CORE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   irq_src,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_CORE-1:0] irq_out,
  output logic [NUM_CORE-1:0] mchk_out
);

  logic [DATA_W-1:0]           status_q;
  logic [NUM_MASKS*DATA_W-1:0] mask_flat;
  logic [NUM_MASKS-1:0]        out_vec;

  irq_sync_bank #(.W(DATA_W), .RSVD(RSVD[DATA_W-1:0])) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (irq_src),
    .sync_out (status_q)
  );

  irq_mask_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CORE(NUM_CORE)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .status    (status_q),
    .mask_flat (mask_flat),
    .bus_rdata (bus_rdata)
  );

  genvar o;
  generate
    for (o = 0; o < NUM_MASKS; o++) begin : g_out
      irq_out_stage #(.W(DATA_W)) u_stage (
        .clk    (clk),
        .rst    (rst),
        .status (status_q),
        .enable (mask_flat[o*DATA_W +: DATA_W]),
        .line_q (out_vec[o])
      );
    end
  endgenerate

  assign irq_out  = out_vec[NUM_CORE-1:0];
  assign mchk_out = out_vec[NUM_MASKS-1:NUM_CORE];

endmodule

// File: rtl/irq_fanout_checker.sv
module irq_fanout_checker
  import irq_fanout_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CORE = 2,
  parameter logic [31:0] RSVD     = 32'hFFFE_0040,
  localparam int unsigned NUM_MASKS = 2 * NUM_CORE
) (
  input logic                          clk,
  input logic                          rst,
  input logic [DATA_W-1:0]             irq_src,
  input logic [DATA_W-1:0]             status_q,
  input logic [NUM_MASKS*DATA_W-1:0]   mask_flat,
  input logic [NUM_MASKS-1:0]          out_vec,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_wr,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic [DATA_W-1:0]             bus_rdata
);

  localparam logic [DATA_W-1:0] RMASK = RSVD[DATA_W-1:0];

  logic any_hit;
  always_comb begin
    any_hit = 1'b0;
    for (int i = 0; i < NUM_MASKS; i++)
      if (bus_addr == ADDR_W'(mask_ofs(i, NUM_CORE))) any_hit = 1'b1;
  end

  // R3: first cycle out of reset is quiet
  a_r3_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_vec == '0 && bus_rdata == '0));

  // R1: status trails the inputs by two edges
  a_r1_sync_latency: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (status_q == ($past(irq_src, 2) & ~RMASK)));

  // R2: reserved bits read back as zero
  a_r2_rsvd_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus_addr) == ADDR_W'(STATUS_OFS)) |-> ((bus_rdata & RMASK) == '0));

  // R9: writes off the mask offsets leave every mask untouched
  a_r9_stray_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !any_hit) |=> $stable(mask_flat));

  genvar i;
  generate
    for (i = 0; i < NUM_MASKS; i++) begin : g_chk
      // R6: registered OR of masked status
      a_r6_registered_or: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_vec[i] ==
          |($past(status_q) & $past(mask_flat[i*DATA_W +: DATA_W]))));
      // R4 / R5: a write at the mask offset lands on the next edge
      a_r4_mask_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(mask_ofs(i, NUM_CORE))) |=>
          (mask_flat[i*DATA_W +: DATA_W] == $past(bus_wdata)));
    end
  endgenerate

endmodule

bind irq_fanout_router irq_fanout_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CORE(NUM_CORE), .RSVD(RSVD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_src   (irq_src),
  .status_q  (status_q),
  .mask_flat (mask_flat),
  .out_vec   (out_vec),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata)
);

// File: tb/sim_irq_fanout_router.sv
`timescale 1ns/1ps
module sim_irq_fanout_router;

  localparam logic [31:0] RSV = 32'hFFFE_0040;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_src = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out, mchk_out;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_fanout_router u0 (
    .clk(clk), .rst(rst), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .mchk_out(mchk_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    edges(1);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    edges(1);
    d = bus_rdata;
  endtask

  function automatic logic [3:0] outs();
    return {mchk_out, irq_out};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R3 outputs after reset", {28'd0, outs()}, 32'd0);
    chk("R3 rdata after reset", bus_rdata, 32'd0);
    rd(8'h10, d); chk("R3 irq mask 0 reset", d, 0);
    rd(8'h14, d); chk("R3 irq mask 1 reset", d, 0);
    rd(8'h18, d); chk("R3 mchk mask 0 reset", d, 0);
    rd(8'h1C, d); chk("R3 mchk mask 1 reset", d, 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    irq_src = 32'hA5A5_1234;
    edges(2);
    rd(8'h00, d); chk("R1 status pattern", d, 32'hA5A5_1234 & ~RSV);
    irq_src = 32'hFFFF_FFFF;
    edges(2);
    rd(8'h00, d); chk("R2 reserved bits zero", d, 32'h0001_FFBF);
    irq_src = 32'h0000_0003;
    edges(2);
    rd(8'h00, d); chk("R1 status low pattern", d, 32'h0000_0003);
    // R1 latency: change input at a negedge, read after a single edge
    irq_src = 32'h0000_0010;
    rd(8'h00, d); chk("R1 one edge still old", d, 32'h0000_0003);
    irq_src = 32'h0;
    edges(3);
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    wr(8'h10, 32'h1111_0001);
    wr(8'h14, 32'h2222_0002);
    wr(8'h18, 32'h4444_0004);
    wr(8'h1C, 32'h8888_0008);
    rd(8'h10, d); chk("R4 irq mask 0 readback", d, 32'h1111_0001);
    rd(8'h14, d); chk("R4 irq mask 1 readback", d, 32'h2222_0002);
    rd(8'h18, d); chk("R5 mchk mask 0 readback", d, 32'h4444_0004);
    rd(8'h1C, d); chk("R5 mchk mask 1 readback", d, 32'h8888_0008);
    bus_addr = 8'h10;
    #1;
    chk("R10 rdata holds before edge", bus_rdata, 32'h8888_0008);
    edges(1);
    chk("R10 rdata after edge", bus_rdata, 32'h1111_0001);
  endtask

  task automatic t_route();
    wr(8'h10, 32'h1); wr(8'h14, 32'h2); wr(8'h18, 32'h4); wr(8'h1C, 32'h8);
    irq_src = 32'h2;
    edges(2);
    chk("R6 no change after two edges", {28'd0, outs()}, 0);
    edges(1);
    chk("R4 bit1 reaches irq_out[1] only", {28'd0, outs()}, 32'h2);
    irq_src = 32'h8;
    edges(3);
    chk("R5 bit3 reaches mchk_out[1] only", {28'd0, outs()}, 32'h8);
    irq_src = 32'h4;
    edges(3);
    chk("R5 bit2 reaches mchk_out[0] only", {28'd0, outs()}, 32'h4);
    // R6: mask change shows one edge later
    wr(8'h18, 32'h0);
    chk("R6 mask write not yet visible", {28'd0, outs()}, 32'h4);
    edges(1);
    chk("R6 mask write visible one edge on", {28'd0, outs()}, 0);
  endtask

  task automatic t_overlap();
    wr(8'h10, 32'h20); wr(8'h14, 32'h20); wr(8'h18, 32'h20); wr(8'h1C, 32'h20);
    irq_src = 32'h20;
    edges(3);
    chk("R7 shared bit drives all four", {28'd0, outs()}, 32'hF);
    irq_src = 32'h0;
    edges(2);
    chk("R8 still high two edges after drop", {28'd0, outs()}, 32'hF);
    edges(1);
    chk("R8 low after source drops", {28'd0, outs()}, 0);
  endtask

  task automatic t_reserved();
    wr(8'h10, '1); wr(8'h14, '1); wr(8'h18, '1); wr(8'h1C, '1);
    irq_src = 32'h0000_0040;
    edges(4);
    chk("R2 bit6 drives nothing", {28'd0, outs()}, 0);
    irq_src = 32'h0010_0000;
    edges(4);
    chk("R2 bit20 drives nothing", {28'd0, outs()}, 0);
    irq_src = 32'h0;
    edges(3);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(8'h10, 32'h0000_0100);
    wr(8'h14, 32'h0); wr(8'h18, 32'h0); wr(8'h1C, 32'h0);
    wr(8'h00, '1); wr(8'h04, '1); wr(8'h20, '1); wr(8'h12, '1);
    rd(8'h10, d); chk("R9 mask 0 untouched", d, 32'h0000_0100);
    rd(8'h14, d); chk("R9 mask 1 untouched", d, 0);
    rd(8'h18, d); chk("R9 mchk mask 0 untouched", d, 0);
    rd(8'h1C, d); chk("R9 mchk mask 1 untouched", d, 0);
    rd(8'h00, d); chk("R9 status unaffected by write", d, 0);
    rd(8'h04, d); chk("R9 unmapped read zero", d, 0);
    rd(8'h12, d); chk("R9 unaligned read zero", d, 0);
    chk("R9 outputs unaffected", {28'd0, outs()}, 0);
  endtask

  task automatic t_same_cycle();
    wr(8'h10, 32'h0);
    // Input rise and mask write commit on the same edge
    bus_addr  = 8'h10;
    bus_wdata = 32'h0000_0100;
    bus_wr    = 1'b1;
    irq_src   = 32'h0000_0100;
    edges(1);
    bus_wr = 1'b0;
    edges(1);
    chk("R6 same cycle: low after two edges", {31'd0, irq_out[0]}, 0);
    edges(1);
    chk("R6 same cycle: high after three edges", {31'd0, irq_out[0]}, 1);
    chk("R4 same cycle: other lines quiet", {28'd0, outs()}, 32'h1);
    irq_src = 32'h0;
    edges(3);
    chk("R8 clears after collision test", {28'd0, outs()}, 0);
  endtask

  initial begin
    edges(4);
    rst = 1'b0;
    edges(1);
    t_reset();
    t_status();
    t_mask_rw();
    t_route();
    t_overlap();
    t_reserved();
    t_ignored();
    t_same_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule